// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an external asynchronous static RAM of 64K words by 4 bits. The RAM has active-low chip-select and write-enable strobes and a shared bidirectional data bus. The host offers one word per request through a request/ready handshake. The controller turns each request into a strobe sequence whose every phase lasts a parameterised number of clock cycles. Each timing minimum of the memory is rounded up to whole clock periods, and a nonzero figure always counts as at least one cycle.

A read holds select low with write enable high for the longer of the access time and the read-cycle minimum. It captures the bus in the last of those cycles and reports the word with a one-cycle valid pulse. Before the host is released, a turnaround wait covers the time the memory may keep driving after select rises. A write is controlled by write enable. Address and data are driven for a setup interval, and then both strobes fall on the same clock edge. They stay low for the longer of the pulse-width and data-setup minimums, then rise together. The address is held for a recovery interval that also pads the write to the full cycle minimum. The bus driver enable covers exactly the setup and strobe phases of a write.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and directly after reset, `ready` is 1, `sr_cs_n` and `sr_we_n` are 1, `sr_oe` is 0 and `rd_valid` is 0.
- R2: A request is taken only at a clock edge where both `req` and `ready` are 1. `ready` stays 0 from that edge until the cycle is complete. A request raised while `ready` is 0 is ignored and leaves memory contents unchanged.
- R3: A read (`req_wr`=0) holds `sr_cs_n`=0 and `sr_we_n`=1 with a stable address for exactly max(T_AA, T_RC) cycles. `rd_data` then equals the word stored at `req_addr`, sampled in the last of those cycles, and `rd_valid` is high for exactly one cycle.
- R4: A write (`req_wr`=1) drives the address and data with `sr_oe`=1 for T_AS cycles with both strobes high. `sr_we_n` and `sr_cs_n` then fall together and stay low for exactly max(T_WP, T_DS) cycles.
- R5: After the strobes rise, the address stays unchanged and `ready` stays 0 for max(T_WR, T_WC − T_AS − max(T_WP, T_DS)) cycles.
- R6: `sr_oe` is never 1 while a read is strobed (`sr_cs_n`=0, `sr_we_n`=1), nor within T_TA cycles after a read strobe ends, so the two sides never drive the bus at once.
- R7: While `sr_we_n` is 0, `sr_oe` is 1 and `sr_addr` and `sr_dout` do not change.
- R8: `sr_we_n` is never 0 while `sr_cs_n` is 1, and in a write `sr_cs_n` never falls before `sr_we_n`.
- R9: Any mix of reads and writes, including a write right after a read, returns for each read the data of the most recent write to that address (0 for addresses never written).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Host request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 4 | Write data |
| ready | output | 1 | Controller can accept a request |
| rd_data | output | 4 | Read data |
| rd_valid | output | 1 | One-cycle pulse: rd_data is valid |
| sr_addr | output | 16 | Memory address |
| sr_cs_n | output | 1 | Memory select, active low |
| sr_we_n | output | 1 | Memory write enable, active low |
| sr_dout | output | 4 | Data toward the memory bus |
| sr_din | input | 4 | Data from the memory bus |
| sr_oe | output | 1 | Enable for the controller's bus driver |

## Verification
On every cycle, the assertions check the following:
- the driver enable stays off during a read strobe and for the turnaround window after it;
- write enable is never low without select;
- select falls together with write enable;
- address and data stay frozen, with the driver on, for as long as the write strobe is low;
- the valid pulse lasts one cycle.

Other properties only the bench's scenarios can show. These are the exact phase lengths, whether read data arrives late or early relative to the access time, and that a stalled request is dropped. They also include a memory model that drives the bus after select rises and flags contention, and read-after-write data across address extremes.

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl #(
  parameter int AW    = 16,
  parameter int DW    = 4,
  parameter int CNT_W = 8,
  parameter int T_AA  = 2,
  parameter int T_RC  = 2,
  parameter int T_AS  = 1,
  parameter int T_WP  = 1,
  parameter int T_DS  = 1,
  parameter int T_WR  = 1,
  parameter int T_WC  = 2,
  parameter int T_TA  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] sr_addr,
  output logic          sr_cs_n,
  output logic          sr_we_n,
  output logic [DW-1:0] sr_dout,
  input  logic [DW-1:0] sr_din,
  output logic          sr_oe
);

  localparam int RD_LEN = (T_AA > T_RC) ? T_AA : T_RC;
  localparam int WP_LEN = (T_WP > T_DS) ? T_WP : T_DS;
  localparam int WR_PAD = T_WC - T_AS - WP_LEN;
  localparam int WR_LEN = (T_WR > WR_PAD) ? T_WR : WR_PAD;
  localparam int AS_LEN = (T_AS > 0) ? T_AS : 1;
  localparam int TA_LEN = (T_TA > 0) ? T_TA : 1;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_TURN, S_WSET, S_WPUL, S_WREC} state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ready    <= 1'b1;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      sr_addr  <= '0;
      sr_cs_n  <= 1'b1;
      sr_we_n  <= 1'b1;
      sr_dout  <= '0;
      sr_oe    <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req && ready) begin
          ready   <= 1'b0;
          sr_addr <= req_addr;
          if (req_wr) begin
            sr_dout <= req_wdata;
            sr_oe   <= 1'b1;
            cnt     <= CNT_W'(AS_LEN - 1);
            st      <= S_WSET;
          end else begin
            sr_cs_n <= 1'b0;
            cnt     <= CNT_W'(RD_LEN - 1);
            st      <= S_READ;
          end
        end
        S_READ: if (last) begin
          rd_data  <= sr_din;
          rd_valid <= 1'b1;
          sr_cs_n  <= 1'b1;
          cnt      <= CNT_W'(TA_LEN - 1);
          st       <= S_TURN;
        end else cnt <= cnt - 1'b1;
        S_TURN: if (last) begin
          ready <= 1'b1;
          st    <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_WSET: if (last) begin
          sr_we_n <= 1'b0;
          sr_cs_n <= 1'b0;
          cnt     <= CNT_W'(WP_LEN - 1);
          st      <= S_WPUL;
        end else cnt <= cnt - 1'b1;
        S_WPUL: if (last) begin
          sr_we_n <= 1'b1;
          sr_cs_n <= 1'b1;
          sr_oe   <= 1'b0;
          cnt     <= CNT_W'(WR_LEN - 1);
          st      <= S_WREC;
        end else cnt <= cnt - 1'b1;
        S_WREC: if (last) begin
          ready <= 1'b1;
          st    <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W-1:0] since_rd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_rd <= CNT_W'(TA_LEN);
    else if (!sr_cs_n && sr_we_n) since_rd <= '0;
    else if (since_rd < CNT_W'(TA_LEN)) since_rd <= since_rd + 1'b1;
  end

  AST_OE_NOT_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_oe && !sr_cs_n && sr_we_n));                                  // R6
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    sr_oe |-> since_rd >= CNT_W'(TA_LEN));                             // R6
  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_we_n |-> !sr_cs_n);                                            // R8
  AST_CS_NOT_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sr_cs_n) && !sr_we_n) |-> $fell(sr_we_n));                  // R8
  AST_OE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_we_n |-> sr_oe);                                               // R7
  AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_we_n && $past(!sr_we_n)) |-> ($stable(sr_addr) && $stable(sr_dout))); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);                                           // R3
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_cs_n || sr_oe) |-> !ready);                                   // R2

endmodule

// File: tb/sram_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sram_seq_ctrl_bench;
  localparam int AA = 3, RC = 2, AS = 1, WP = 2, DS = 3, WR = 1, WC = 7, TA = 2;
  localparam int E_RD  = (AA > RC) ? AA : RC;
  localparam int E_WP  = (WP > DS) ? WP : DS;
  localparam int E_WR  = (WR > WC - AS - E_WP) ? WR : WC - AS - E_WP;

  logic clk = 0, rst_n = 0;
  logic req = 0, req_wr = 0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic ready, rd_valid, sr_cs_n, sr_we_n, sr_oe;
  logic [3:0] rd_data, sr_dout, sr_din;
  logic [15:0] sr_addr;

  always #10 clk = ~clk;

  sram_seq_ctrl #(.T_AA(AA), .T_RC(RC), .T_AS(AS), .T_WP(WP), .T_DS(DS),
                  .T_WR(WR), .T_WC(WC), .T_TA(TA)) u_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .sr_addr(sr_addr), .sr_cs_n(sr_cs_n), .sr_we_n(sr_we_n), .sr_dout(sr_dout),
    .sr_din(sr_din), .sr_oe(sr_oe));

  int tests = 0, fails = 0;
  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  logic [3:0] mem [int];
  logic [3:0] shadow [int];
  logic [3:0] expq [$];

  function automatic logic [3:0] rdm(input int a);
    return mem.exists(a) ? mem[a] : 4'h0;
  endfunction

  int rd_w = 0, rel = 0, wp_w = 0, su_w = 0, rec_w = 0;
  bit in_rec = 0;
  logic prev_we = 1, prev_cs = 1, prev_rv = 0;
  logic [15:0] prev_addr = '0, wa;
  logic [3:0] prev_dout = '0, wd;

  assign sr_din = (!sr_cs_n && sr_we_n && rd_w >= AA) ? rdm(int'(sr_addr))
                                                      : ~rdm(int'(sr_addr));

  always @(negedge clk) if (rst_n) begin
    if (sr_oe && ((!sr_cs_n && sr_we_n) || rel > 0))
      chk(0, "R6 bus contention", 1, 0);
    if (!sr_we_n && sr_cs_n) chk(0, "R8 we low without cs", 1, 0);
    if (!sr_cs_n && sr_we_n) begin
      if (sr_addr != prev_addr && rd_w > 0) rd_w = 0;
      rd_w++; rel = TA;
    end else begin
      if (rd_w > 0) chk(rd_w == E_RD, "R3 read strobe length", rd_w, E_RD);
      rd_w = 0;
      if (rel > 0) rel--;
    end
    if (sr_oe && sr_we_n && sr_cs_n && !in_rec) su_w++;
    if (!sr_we_n) begin
      if (prev_we) chk(su_w == AS, "R4 setup length", su_w, AS);
      if (!prev_we) chk(sr_addr == prev_addr && sr_dout == prev_dout,
                        "R7 stable during strobe", {sr_addr, sr_dout}, {prev_addr, prev_dout});
      chk(sr_oe, "R7 oe during strobe", sr_oe, 1);
      wp_w++; wa = sr_addr; wd = sr_dout;
    end else if (!prev_we) begin
      chk(wp_w == E_WP, "R4 strobe length", wp_w, E_WP);
      mem[int'(wa)] = wd;
      wp_w = 0; su_w = 0; in_rec = 1; rec_w = 0;
    end
    if (in_rec) begin
      if (ready) begin
        chk(rec_w == E_WR, "R5 recovery length", rec_w, E_WR);
        in_rec = 0;
      end else begin
        chk(sr_addr == wa, "R5 address held", sr_addr, wa);
        rec_w++;
      end
    end
    if (rd_valid) begin
      chk(!prev_rv, "R3 single valid pulse", prev_rv, 0);
      if (expq.size() == 0) chk(0, "R3 unexpected valid", 1, 0);
      else begin
        logic [3:0] e;
        e = expq.pop_front();
        chk(rd_data == e, "R9 read data", rd_data, e);
      end
    end
    prev_we = sr_we_n; prev_cs = sr_cs_n; prev_rv = rd_valid;
    prev_addr = sr_addr; prev_dout = sr_dout;
  end

  task automatic op(input bit w, input logic [15:0] a, input logic [3:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; req_wr = w; req_addr = a; req_wdata = d;
    if (w) shadow[int'(a)] = d;
    else expq.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0);
    @(negedge clk);
    req = 0;
    chk(ready == 0, "R2 ready low after accept", ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1 && sr_cs_n && sr_we_n && !sr_oe && !rd_valid, "R1 reset state",
        {ready, sr_cs_n, sr_we_n, sr_oe, rd_valid}, 5'b11100);
    rst_n = 1;
    @(negedge clk);
    chk(ready == 1 && sr_cs_n && sr_we_n && !sr_oe, "R1 after reset",
        {ready, sr_cs_n, sr_we_n, sr_oe}, 4'b1110);
    op(1, 16'h0000, 4'hA);
    op(1, 16'hFFFF, 4'h5);
    op(1, 16'h1234, 4'hC);
    op(0, 16'h0000, 0);
    op(0, 16'hFFFF, 0);
    op(1, 16'h0005, 4'h3);
    op(0, 16'h1234, 0);
    op(1, 16'h1234, 4'h7);
    op(0, 16'h1234, 0);
    op(0, 16'h0042, 0);
    op(0, 16'h0005, 0);
    // R2: request while busy is ignored
    op(0, 16'h0001, 0);
    req = 1; req_wr = 1; req_addr = 16'h0005; req_wdata = 4'hF;
    @(negedge clk);
    req = 0;
    op(0, 16'h0005, 0);
    for (int i = 0; i < 8; i++) op(1, 16'(i * 16'h2111), 4'(i + 1));
    for (int i = 7; i >= 0; i--) op(0, 16'(i * 16'h2111), 0);
    @(negedge clk);
    while (!ready) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R9 all reads returned", expq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog timeout", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule